// File: doc/BRIEF.md
# Half-Duplex Back-Pressure Carrier Generator

This block applies flow control on a shared half-duplex medium by holding a false carrier on the line. While the enable input is high and the medium has been quiet long enough, the block drives continuous preamble nibbles. Other stations sense this carrier and defer, so no new frames reach the local receiver. The block runs on a nibble clock, so one clock is one nibble, or four bit times. The real frame path sits outside the block and uses the preamble-select output to hand the transmit pins to this generator.

If the false carrier collides with another station, the block first keeps driving until a minimum presence on the wire is reached. It then drops the line and asks an external backoff timer for a delay. The request carries the running collision count, which the timer uses to pick its random slot range. The block stays silent until the timer reports that the delay is over. It then raises carrier again under the same medium-idle rules as before.

Top module: `bp_carrier_gen`

## Requirements
- R1: During reset and in the cycle after a reset cycle, `tx_en`, `pre_sel` and `bo_req` are 0, `txd` is 4'b0000 and `bo_attempt` is 0.
- R2: Carrier rises (`tx_en` = 1) in the cycle after an idle cycle in which `bp_en` = 1 and `crs` = 0, provided the previous IPG_NIB cycles had neither `crs` nor `tx_en`. While `tx_en` = 1, `pre_sel` = 1 and `txd` = 4'b0101.
- R3: Carrier is never raised in the cycle after one in which `crs` = 1. Each cycle with `crs` restarts the IPG_NIB quiet count.
- R4: If `bp_en` is 0 during a carrier cycle with no collision so far and no `col` in that cycle, carrier drops in the next cycle. The IPG_NIB quiet rule of R2 then applies. A `col` in the same cycle as the enable drop takes the collision path instead.
- R5: After a collision, the carrier run lasts at least MIN_NIB cycles (default 24 = 96 bit times). The run is exactly MIN_NIB cycles if `col` came before that count was reached. If `col` came on or after the MIN_NIB-th cycle, the run ends right after the collision cycle.
- R6: A collision run ends with a one-cycle `bo_req` pulse in the first silent cycle. In that same cycle, `bo_attempt` equals its previous value plus one, saturating at 2^ATT_W-1.
- R7: From the `bo_req` cycle through the cycle in which `bo_done` = 1 is sampled, `tx_en` stays 0. After that, carrier is raised again only under R2.
- R8: `col` while the line is not driven, or a second `col` during the minimum-presence hold, raises no `bo_req` and leaves `bo_attempt` unchanged.
- R9: `bo_attempt` is kept across retries while `bp_en` = 1. It clears in the cycle after an idle, non-backoff cycle with `bp_en` = 0.
- R10: While `bp_en` = 0 and the line is not driven, carrier is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bp_en | input | 1 | Back-pressure enable |
| crs | input | 1 | Carrier sense from the line |
| col | input | 1 | Collision indication from the line |
| bo_done | input | 1 | Backoff timer reports the delay is over |
| tx_en | output | 1 | Transmit enable for the false carrier |
| pre_sel | output | 1 | Selects this generator's nibbles onto the transmit pins |
| txd | output | 4 | Transmit nibble, preamble while driving |
| bo_req | output | 1 | One-cycle request to start a backoff delay |
| bo_attempt | output | ATT_W | Collision count for the backoff range |

## Verification
The bench builds the block with IPG_NIB = 6, MIN_NIB = 24 and ATT_W = 3. The short quiet gap puts many raise, drop and re-raise sequences within a short run. Keeping the minimum presence at its true 96-bit value means the hold length is measured at the real size, including collisions before, exactly at and after the 24th nibble. The 3-bit attempt width lets a handful of collisions reach the saturation point of the counter. Clearing of the counter is also exercised.

// File: rtl/bp_pkg.sv
// Shared types and constants for the back-pressure carrier generator.
package bp_pkg;
    // Control states of the carrier generator.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RAISE   = 2'd1,
        ST_HOLD    = 2'd2,
        ST_BACKOFF = 2'd3
    } bp_state_e;

    // Nibble driven while the false carrier is up.
    localparam logic [3:0] PREAMBLE_NIB = 4'b0101;
endpackage

// File: rtl/bp_gap_timer.sv
// Quiet-gap timer.
// What it does: counts consecutive cycles in which the line is neither
// sensed busy nor driven by this block, saturating at IPG_NIB. gap_ok
// says the full inter-packet gap has elapsed.
// Assumes: one clock per nibble; IPG_NIB >= 1; the line counts as idle
// out of reset.
module bp_gap_timer #(
    parameter int IPG_NIB = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic gap_ok
);
    localparam int GW = $clog2(IPG_NIB + 1);
    localparam logic [GW-1:0] GAP_FULL = GW'(IPG_NIB);

    logic [GW-1:0] quiet_q;

    // Restart on any activity, otherwise count up to the full gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q <= GAP_FULL;
        end else if (busy) begin
            quiet_q <= '0;
        end else if (quiet_q != GAP_FULL) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assign gap_ok = (quiet_q == GAP_FULL);
endmodule

// File: rtl/bp_presence_ctr.sv
// Presence counter.
// What it does: counts the nibbles of the current carrier run, starting
// at 1 in the first driven cycle and saturating at MIN_NIB. min_met is
// high in the cycle holding the MIN_NIB-th nibble and afterwards.
// Assumes: start is only pulsed in a cycle where drive is low.
module bp_presence_ctr #(
    parameter int MIN_NIB = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic drive,
    output logic min_met
);
    localparam int PW = $clog2(MIN_NIB + 1);
    localparam logic [PW-1:0] PRES_FULL = PW'(MIN_NIB);

    logic [PW-1:0] pres_q;

    // Load on start, count while driving, clear when silent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_q <= '0;
        end else if (start) begin
            pres_q <= PW'(1);
        end else if (drive) begin
            if (pres_q != PRES_FULL) begin
                pres_q <= pres_q + 1'b1;
            end
        end else begin
            pres_q <= '0;
        end
    end

    assign min_met = (pres_q == PRES_FULL);
endmodule

// File: rtl/bp_carrier_fsm.sv
// Carrier control state machine.
// What it does: decides when to raise the false carrier, when a
// collision forces a minimum hold, and when to hand over to the backoff
// timer. It also keeps the saturating collision count.
// Assumes: gap_ok and min_met come from the gap timer and presence
// counter; bo_done is only meaningful while in backoff.
module bp_carrier_fsm
    import bp_pkg::*;
#(
    parameter int ATT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bp_en,
    input  logic             crs,
    input  logic             col,
    input  logic             gap_ok,
    input  logic             min_met,
    input  logic             bo_done,
    output logic             drive,
    output logic             start,
    output logic             bo_req,
    output logic [ATT_W-1:0] bo_attempt
);
    localparam logic [ATT_W-1:0] ATT_MAX = '1;

    bp_state_e  state_q, state_d;
    logic       collide;
    logic [ATT_W-1:0] att_q;

    // Next-state selection; a collision takes priority over an enable drop.
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        collide = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (bp_en && !crs && gap_ok) begin
                    state_d = ST_RAISE;
                    start   = 1'b1;
                end
            end
            ST_RAISE: begin
                if (col) begin
                    if (min_met) begin
                        state_d = ST_BACKOFF;
                        collide = 1'b1;
                    end else begin
                        state_d = ST_HOLD;
                    end
                end else if (!bp_en) begin
                    state_d = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (min_met) begin
                    state_d = ST_BACKOFF;
                    collide = 1'b1;
                end
            end
            ST_BACKOFF: begin
                if (bo_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Backoff request pulse, one cycle on the first silent cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bo_req <= 1'b0;
        end else begin
            bo_req <= collide;
        end
    end

    // Collision count: bump on each collision, clear when idle and disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            att_q <= '0;
        end else if (collide) begin
            if (att_q != ATT_MAX) begin
                att_q <= att_q + 1'b1;
            end
        end else if (state_q == ST_IDLE && !bp_en) begin
            att_q <= '0;
        end
    end

    assign drive      = (state_q == ST_RAISE) || (state_q == ST_HOLD);
    assign bo_attempt = att_q;
endmodule

// File: rtl/bp_carrier_gen.sv
// Half-duplex back-pressure carrier generator, top level.
// What it does: while bp_en is high and the line is quiet, drives
// preamble to keep other stations deferring. On a collision it enforces
// a minimum presence, drops the line and waits for the backoff timer.
// Assumes: one clock per nibble; the backoff timer answers bo_req with a
// bo_done pulse; crs also reflects this block's own transmission.
module bp_carrier_gen
    import bp_pkg::*;
#(
    parameter int IPG_NIB = 24,
    parameter int MIN_NIB = 24,
    parameter int ATT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bp_en,
    input  logic             crs,
    input  logic             col,
    input  logic             bo_done,
    output logic             tx_en,
    output logic             pre_sel,
    output logic [3:0]       txd,
    output logic             bo_req,
    output logic [ATT_W-1:0] bo_attempt
);
    logic drive;
    logic start;
    logic gap_ok;
    logic min_met;

    bp_gap_timer #(.IPG_NIB(IPG_NIB)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (crs | drive),
        .gap_ok (gap_ok)
    );

    bp_presence_ctr #(.MIN_NIB(MIN_NIB)) u_pres (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .drive   (drive),
        .min_met (min_met)
    );

    bp_carrier_fsm #(.ATT_W(ATT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bp_en      (bp_en),
        .crs        (crs),
        .col        (col),
        .gap_ok     (gap_ok),
        .min_met    (min_met),
        .bo_done    (bo_done),
        .drive      (drive),
        .start      (start),
        .bo_req     (bo_req),
        .bo_attempt (bo_attempt)
    );

    // Output drive: preamble nibbles only while the carrier is up.
    assign tx_en   = drive;
    assign pre_sel = drive;
    assign txd     = drive ? PREAMBLE_NIB : 4'b0000;
endmodule

// File: rtl/bp_carrier_chk.sv
// Property checker for bp_carrier_gen, attached with bind below.
// What it does: tracks run length, hold and backoff windows from the
// ports and checks the timing rules on them.
// Assumes: the same parameter values as the instance it is bound to.
module bp_carrier_chk #(
    parameter int MIN_NIB = 24,
    parameter int ATT_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bp_en,
    input logic             crs,
    input logic             col,
    input logic             bo_done,
    input logic             tx_en,
    input logic             bo_req,
    input logic [ATT_W-1:0] bo_attempt
);
    localparam int RW = $clog2(MIN_NIB + 1);
    localparam logic [RW-1:0] RUN_FULL = RW'(MIN_NIB);
    localparam logic [ATT_W-1:0] ATT_MAX = '1;

    logic [RW-1:0] run_q;
    logic          tx_d;
    logic          hold_q;
    logic          wait_q;

    // Observe run length, collision-hold and backoff windows at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            tx_d   <= 1'b0;
            hold_q <= 1'b0;
            wait_q <= 1'b0;
        end else begin
            tx_d   <= tx_en;
            hold_q <= tx_en && (hold_q || col);
            wait_q <= (bo_req || wait_q) && !bo_done;
            if (tx_en) begin
                if (!tx_d) begin
                    run_q <= RW'(1);
                end else if (run_q != RUN_FULL) begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!tx_en && !bo_req && bo_attempt == '0));

    a_r2_raise_cond: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> ($past(bp_en) && !$past(crs)));

    a_r3_defer_crs: assert property (@(posedge clk) disable iff (!rst_n)
        (crs && !tx_en) |=> !tx_en);

    a_r4_drop_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !bp_en && !col && !hold_q) |=> !tx_en);

    a_r5_min_presence: assert property (@(posedge clk) disable iff (!rst_n)
        bo_req |-> (run_q >= RUN_FULL));

    a_r6_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bo_req |=> !bo_req);

    a_r6_req_at_drop: assert property (@(posedge clk) disable iff (!rst_n)
        bo_req |-> $fell(tx_en));

    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        bo_req |-> (($past(bo_attempt) == ATT_MAX) ? (bo_attempt == ATT_MAX)
                                                   : (bo_attempt == $past(bo_attempt) + 1'b1)));

    a_r7_silent_backoff: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q |-> !tx_en);

    a_r8_count_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bo_attempt) |-> (bo_req || bo_attempt == '0));

    a_r9_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !bp_en && !wait_q && !bo_req) |=> (bo_attempt == '0));

    a_r10_no_raise_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!bp_en && !tx_en) |=> !tx_en);
endmodule

bind bp_carrier_gen bp_carrier_chk #(
    .MIN_NIB (MIN_NIB),
    .ATT_W   (ATT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bp_en      (bp_en),
    .crs        (crs),
    .col        (col),
    .bo_done    (bo_done),
    .tx_en      (tx_en),
    .bo_req     (bo_req),
    .bo_attempt (bo_attempt)
);

// File: tb/bp_carrier_gen_tb.sv
// Bench for bp_carrier_gen: behavioural reference model compared every
// cycle, plus directed measurements of gaps, run lengths and counts.
module bp_carrier_gen_tb;
    localparam int IPG = 6;
    localparam int MIN = 24;
    localparam int ATT = 3;
    localparam int ATT_TOP = (1 << ATT) - 1;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           bp_en, crs, col, bo_done;
    logic           tx_en, pre_sel, bo_req;
    logic [3:0]     txd;
    logic [ATT-1:0] bo_attempt;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string tag   = "R1";

    bp_carrier_gen #(.IPG_NIB(IPG), .MIN_NIB(MIN), .ATT_W(ATT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bp_en(bp_en), .crs(crs), .col(col),
        .bo_done(bo_done), .tx_en(tx_en), .pre_sel(pre_sel), .txd(txd),
        .bo_req(bo_req), .bo_attempt(bo_attempt)
    );

    always #5 clk = ~clk;

    // Reference model: 0 silent, 1 carrier, 2 collision hold, 3 backoff.
    int m_mode, m_run, m_quiet, m_att, q_prev;
    bit m_req, m_busy, m_valid = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_run = 0; m_quiet = IPG; m_att = 0; m_req = 0;
        end else begin
            m_busy  = crs || m_mode == 1 || m_mode == 2;
            q_prev  = m_quiet;
            m_quiet = m_busy ? 0 : ((m_quiet < IPG) ? m_quiet + 1 : IPG);
            m_req   = 0;
            case (m_mode)
                0: begin
                    if (!bp_en) m_att = 0;
                    if (bp_en && !crs && q_prev == IPG) begin m_mode = 1; m_run = 1; end
                end
                1: begin
                    if (col) begin
                        if (m_run >= MIN) begin
                            m_mode = 3; m_req = 1;
                            if (m_att < ATT_TOP) m_att++;
                        end else begin
                            m_mode = 2; m_run++;
                        end
                    end else if (!bp_en) m_mode = 0;
                    else if (m_run < MIN) m_run++;
                end
                2: begin
                    if (m_run >= MIN) begin
                        m_mode = 3; m_req = 1;
                        if (m_att < ATT_TOP) m_att++;
                    end else m_run++;
                end
                default: if (bo_done) m_mode = 0;
            endcase
        end
        m_valid = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // Every-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (m_valid) begin
            bit etx;
            etx = (m_mode == 1 || m_mode == 2);
            chk(tx_en == etx && pre_sel == etx, {tag, " tx_en/pre_sel"}, int'(tx_en), int'(etx));
            chk(txd == (etx ? 4'b0101 : 4'b0000), {tag, " txd"}, int'(txd), etx ? 5 : 0);
            chk(bo_req == m_req, {tag, " bo_req"}, int'(bo_req), int'(m_req));
            chk(int'(bo_attempt) == m_att, {tag, " bo_attempt"}, int'(bo_attempt), m_att);
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    // Wait for carrier to rise; returns negedges waited.
    task automatic wait_rise(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tx_en && n < 500);
    endtask

    // With carrier up at run 1, collide at run 'at' (second hit at run
    // 'at2' if nonzero); returns the observed run length.
    task automatic collide_run(input int at, input int at2, output int len);
        len = 1;
        for (int i = 2; i <= at; i++) begin
            @(negedge clk);
            len++;
        end
        col = 1'b1;
        forever begin
            @(negedge clk);
            col = 1'b0;
            if (!tx_en) break;
            len++;
            if (len == at2) col = 1'b1;
        end
    endtask

    task automatic end_backoff(input int wait_n);
        for (int i = 0; i < wait_n; i++) begin
            @(negedge clk);
            chk(!tx_en, "R7 silent in backoff", int'(tx_en), 0);
        end
        bo_done = 1'b1;
        @(negedge clk);
        bo_done = 1'b0;
    endtask

    initial begin
        int n, len;
        rst_n = 1'b0; bp_en = 1'b0; crs = 1'b0; col = 1'b0; bo_done = 1'b0;
        repeat (3) @(negedge clk);
        chk(!tx_en && !pre_sel && txd == 4'b0000 && !bo_req && bo_attempt == '0,
            "R1 reset outputs", int'(tx_en), 0);
        rst_n = 1'b1;

        // R10 and R8: disabled, collisions on an idle line change nothing.
        tag = "R10";
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            col = ~col;
            chk(!tx_en && bo_attempt == '0, "R10 no raise while disabled", int'(tx_en), 0);
        end
        col = 1'b0;
        @(negedge clk);
        chk(!bo_req, "R8 idle collision ignored", int'(bo_req), 0);

        // R3: enabled but carrier present.
        tag = "R3";
        crs = 1'b1; bp_en = 1'b1;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            chk(!tx_en, "R3 defer to carrier", int'(tx_en), 0);
        end
        crs = 1'b0;
        tag = "R2";
        wait_rise(n);
        chk(n == IPG + 1, "R2 gap after carrier", n, IPG + 1);
        chk(txd == 4'b0101 && pre_sel, "R2 preamble nibble", int'(txd), 5);

        // R4: drop enable mid-carrier.
        tag = "R4";
        repeat (29) @(negedge clk);
        bp_en = 1'b0;
        @(negedge clk);
        chk(!tx_en, "R4 stop next nibble", int'(tx_en), 0);
        bp_en = 1'b1;
        wait_rise(n);
        chk(n == IPG + 1, "R4 gap after own carrier", n, IPG + 1);

        // R5/R6: early collision.
        tag = "R5";
        collide_run(5, 0, len);
        chk(len == MIN, "R5 early collision run", len, MIN);
        chk(bo_req && bo_attempt == 3'd1, "R6 request and count", int'(bo_attempt), 1);
        tag = "R7";
        end_backoff(40);
        wait_rise(n);
        chk(n == 1, "R7 re-raise after done", n, 1);

        // R5: collision exactly at MIN and after MIN.
        tag = "R5";
        collide_run(MIN, 0, len);
        chk(len == MIN, "R5 collision at boundary", len, MIN);
        chk(int'(bo_attempt) == 2, "R6 second count", int'(bo_attempt), 2);
        end_backoff(10);
        wait_rise(n);
        collide_run(30, 0, len);
        chk(len == 30, "R5 late collision ends at once", len, 30);
        chk(int'(bo_attempt) == 3, "R6 third count", int'(bo_attempt), 3);

        // R8: second collision during hold, and collision during backoff.
        tag = "R8";
        col = 1'b1;
        @(negedge clk);
        col = 1'b0;
        end_backoff(8);
        chk(int'(bo_attempt) == 3, "R8 backoff collision ignored", int'(bo_attempt), 3);
        wait_rise(n);
        chk(int'(bo_attempt) == 3, "R9 kept across retry", int'(bo_attempt), 3);
        collide_run(3, 10, len);
        chk(len == MIN, "R8 second hit in hold", len, MIN);
        chk(int'(bo_attempt) == 4, "R8 counted once", int'(bo_attempt), 4);

        // R6 saturation.
        tag = "R6";
        for (int k = 0; k < 5; k++) begin
            end_backoff(3);
            wait_rise(n);
            collide_run(2, 0, len);
        end
        chk(int'(bo_attempt) == ATT_TOP, "R6 saturation", int'(bo_attempt), ATT_TOP);

        // R4: collision and enable drop together.
        tag = "R4";
        end_backoff(3);
        wait_rise(n);
        bp_en = 1'b0; col = 1'b1;
        @(negedge clk);
        col = 1'b0;
        chk(tx_en, "R4 collision wins over disable", int'(tx_en), 1);
        while (tx_en) @(negedge clk);
        chk(bo_req, "R4 collision path request", int'(bo_req), 1);

        // R9: clear when idle and disabled.
        tag = "R9";
        end_backoff(3);
        repeat (2) @(negedge clk);
        chk(bo_attempt == '0, "R9 cleared when disabled", int'(bo_attempt), 0);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule